// File: doc/BRIEF.md
# Microsecond Free-Running Timer

A 12-bit up-counter that advances once per microsecond and never stops. The microsecond step comes from an internal clock-enable divider, so the whole block runs in the system clock domain. Software reads the count over an 8-bit register bus through two read-only addresses: the low byte sits at the base address and the upper four bits sit at the next address up.

The counter is wider than the bus, so a two-step read could combine two different count values if the count moves between the accesses. To prevent this, a read of the low byte copies the upper four count bits into a holding register in the same access. A later read of the upper address returns that held value instead of the live count. The two reads therefore always describe one instant.

The block also produces two periodic interrupt requests. Each request is a one-cycle pulse, issued when a chosen counter bit goes from 0 to 1. By default bit 6 gives a pulse every 128 µs and bit 9 gives one every 1.024 ms. Masking, vectoring and address decoding for the wider bus stay outside this block.

Top module: `usec_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, the count is 0, reads of both addresses return 0x00, and both interrupt outputs are low.
- R2: The count rises by exactly one every DIV system clocks and wraps from 4095 to 0. Nothing loads it and nothing stops it.
- R3: When `rd_addr` equals BASE_ADDR, `rd_data` shows count bits 7:0 in the same cycle.
- R4: A clock edge with `rd_en` high and `rd_addr` equal to BASE_ADDR copies count bits 11:8 into the holding register. The value copied is the count seen in that same access.
- R5: When `rd_addr` equals BASE_ADDR+1, `rd_data` bits 3:0 show the holding register, not the live count, and bits 7:4 are 0.
- R6: The holding register keeps its value on every edge that is not a low-byte read with `rd_en` high. This includes upper-address reads, reads of other addresses, and low-address cycles with `rd_en` low.
- R7: `fast_tick_o` is high for exactly one clock cycle each time count bit FAST_BIT (default 6) goes from 0 to 1, and it is low at all other times.
- R8: `slow_tick_o` is high for exactly one clock cycle each time count bit SLOW_BIT (default 9) goes from 0 to 1, and it is low at all other times.
- R9: Any address other than BASE_ADDR and BASE_ADDR+1 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe for the current bus cycle |
| rd_addr | input | ADDR_W | Register address being read |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| fast_tick_o | output | 1 | One-cycle pulse on each rise of count bit FAST_BIT |
| slow_tick_o | output | 1 | One-cycle pulse on each rise of count bit SLOW_BIT |

## Verification
The bench runs the counter through three full wraps with a short divider. The read pattern repeats every seven cycles, and seven is coprime with the divider, so low-byte reads fall at every phase of the tick. That includes the edge where the low byte rolls from 0xFF to 0x00: a design that returned the live upper nibble would give a value one higher than the held one there.

Upper-address reads, strobed reads of unmapped addresses and unstrobed low-address cycles are placed between each snapshot and its readback. A design that updated the holding register on any of them would return a newer nibble. Both tick outputs are compared every cycle against the rise of the counter bit, and their pulses are totalled over the run. A design that held a pulse for the whole tick period, or fired on a falling edge, would miss either the per-cycle comparison or the total.

// File: rtl/usec_timer.sv
module usec_timer #(
  parameter int DIV       = 125,
  parameter int CNT_W     = 12,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30,
  parameter int FAST_BIT  = 6,
  parameter int SLOW_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fast_tick_o,
  output logic              slow_tick_o
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int DIV_W = $clog2(DIV + 1);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  hold_q;
  logic             fast_prev_q, slow_prev_q;
  logic             tick, lo_sel, hi_sel;

  assign tick   = (div_q == DIV_W'(DIV - 1));
  assign lo_sel = (rd_addr == BASE_ADDR);
  assign hi_sel = (rd_addr == HI_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q       <= '0;
      cnt_q       <= '0;
      hold_q      <= '0;
      fast_prev_q <= 1'b0;
      slow_prev_q <= 1'b0;
    end else begin
      div_q       <= tick ? '0 : div_q + 1'b1;
      cnt_q       <= cnt_q + {{(CNT_W-1){1'b0}}, tick};
      fast_prev_q <= cnt_q[FAST_BIT];
      slow_prev_q <= cnt_q[SLOW_BIT];
      if (rd_en && lo_sel) hold_q <= cnt_q[CNT_W-1:DATA_W];
    end
  end

  assign fast_tick_o = cnt_q[FAST_BIT] & ~fast_prev_q;
  assign slow_tick_o = cnt_q[SLOW_BIT] & ~slow_prev_q;

  always_comb begin
    rd_data = '0;
    if (lo_sel)      rd_data = cnt_q[DATA_W-1:0];
    else if (hi_sel) rd_data = {{(DATA_W-HI_W){1'b0}}, hold_q};
  end
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
  parameter int CNT_W    = 12,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30,
  parameter int FAST_BIT = 6,
  parameter int SLOW_BIT = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [DATA_W-1:0]        rd_data,
  input logic [CNT_W-1:0]         cnt,
  input logic [CNT_W-DATA_W-1:0]  hold,
  input logic                     fast_o,
  input logic                     slow_o
);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> cnt == $past(cnt) + CNT_W'(1)); // R2
  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == BASE_ADDR) |=> hold == $past(cnt[CNT_W-1:DATA_W])); // R4
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == HI_ADDR) |-> rd_data[DATA_W-1:CNT_W-DATA_W] == '0); // R5
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == BASE_ADDR) |=> $stable(hold)); // R6
  AST_FAST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    fast_o |-> $rose(cnt[FAST_BIT])); // R7
  AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fast_o |=> !fast_o); // R7
  AST_SLOW_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_o |-> $rose(cnt[SLOW_BIT])); // R8
  AST_SLOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_o |=> !slow_o); // R8
endmodule

bind usec_timer usec_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
  .FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .cnt(cnt_q), .hold(hold_q), .fast_o(fast_tick_o), .slow_o(slow_tick_o)
);

// File: tb/usec_timer_bench.sv
module usec_timer_bench;
  localparam int DIV = 3;
  localparam logic [7:0] LO = 8'h30;
  localparam logic [7:0] HI = 8'h31;
  localparam int CYCLES = 3 * 4096 * DIV + 50;

  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_addr = LO;
  logic [7:0] rd_data;
  logic fast_tick_o, slow_tick_o;
  int n_edges = 0, n_checks = 0, n_fails = 0;
  int fast_cnt = 0, slow_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usec_timer #(.DIV(DIV), .BASE_ADDR(LO)) u_usec_timer (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .fast_tick_o(fast_tick_o), .slow_tick_o(slow_tick_o)
  );

  always @(posedge clk) n_edges <= rst_n ? n_edges + 1 : 0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, n_edges);
    end
  endtask

  function automatic int model(input int e);
    return (e / DIV) % 4096;
  endfunction

  initial begin
    #200000000;
    n_fails++; n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    int exp_hold = 0;
    repeat (4) @(negedge clk);
    rd_addr = LO; #1;
    check("R1 low during reset", rd_data, 0);
    check("R1 fast during reset", fast_tick_o, 0);
    check("R1 slow during reset", slow_tick_o, 0);
    rd_addr = HI; #1;
    check("R1 high during reset", rd_data, 0);
    rst_n = 1'b1;
    for (int i = 0; i < CYCLES; i++) begin
      int c, p, op;
      @(negedge clk);
      c = model(n_edges);
      p = (n_edges == 0) ? 0 : model(n_edges - 1);
      op = i % 7;
      if (i == 0) begin
        rd_addr = LO; rd_en = 1'b0; #1;
        check("R1 low after reset", rd_data, 0);
      end
      check("R7 fast pulse", fast_tick_o, ((c >> 6) & 1) & ~((p >> 6) & 1));
      check("R8 slow pulse", slow_tick_o, ((c >> 9) & 1) & ~((p >> 9) & 1));
      fast_cnt += fast_tick_o;
      slow_cnt += slow_tick_o;
      case (op)
        0: begin rd_en = 1'b1; rd_addr = LO; #1;
             check("R3 low byte", rd_data, c & 8'hFF);
             check("R2 count step", rd_data, model(n_edges) & 8'hFF); end
        1: begin rd_en = 1'b1; rd_addr = HI; #1;
             check("R5 held upper", rd_data, exp_hold); end
        2: begin rd_en = 1'b0; rd_addr = HI; #1;
             check("R6 hold after high read", rd_data, exp_hold); end
        3: begin rd_en = 1'b1; rd_addr = 8'h7A; #1;
             check("R9 unmapped zero", rd_data, 0); end
        4: begin rd_en = 1'b0; rd_addr = LO; #1;
             check("R3 low unstrobed", rd_data, c & 8'hFF); end
        5: begin rd_en = 1'b1; rd_addr = HI; #1;
             check("R6 hold after unmapped/unstrobed", rd_data, exp_hold); end
        default: begin rd_en = 1'b0; rd_addr = 8'h2F; #1;
             check("R9 address below base", rd_data, 0); end
      endcase
      if (op == 0) exp_hold = (c >> 8) & 4'hF;
    end
    @(negedge clk);
    rd_en = 1'b0; rd_addr = HI; #1;
    check("R4 final snapshot", rd_data, exp_hold);
    check("R2 wrap count", model(n_edges), ((n_edges / DIV) & 12'hFFF));
    check("R7 fast pulse total", fast_cnt, ((CYCLES / DIV) / 128 + 1) / 2 * 0 + fast_cnt_expected(CYCLES));
    check("R8 slow pulse total", slow_cnt, slow_cnt_expected(CYCLES));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  function automatic int rises(input int last_edge, input int bitn);
    int r = 0;
    for (int e = 1; e <= last_edge; e++)
      if (((model(e) >> bitn) & 1) == 1 && ((model(e - 1) >> bitn) & 1) == 0) r++;
    return r;
  endfunction

  function automatic int fast_cnt_expected(input int cyc);
    return rises(cyc - 1, 6);
  endfunction

  function automatic int slow_cnt_expected(input int cyc);
    return rises(cyc - 1, 9);
  endfunction
endmodule